// File: doc/BRIEF.md
# Virtual Address Segment and Privilege Checker

This block is the first stage of address translation. Every virtual address passes through it before any TLB is consulted. It decodes the current operating mode from the processor status word. It checks data accesses for natural alignment. It recognises the two unmapped kernel windows and maps them straight to physical space. It rejects use of the cached kernel window from a less privileged mode. It also reports from the address alone whether the access may be cached.

Any address outside the two unmapped windows that raises no fault is passed on with a "needs TLB" flag. Every result is registered, so it appears one clock after the request, together with a valid strobe.

Top module: `addr_seg_check`

## Requirements
- R1: Mode (`mode` output, 0 = kernel, 1 = supervisor, 2 = user) is kernel whenever status bit 28, bit 2 or bit 1 is set, or when status bits 4:3 equal 00.
- R2: With none of those kernel conditions present, status bits 4:3 = 01 give supervisor, and 10 or 11 give user.
- R3: A data access (`acc_kind` nonzero) of 2^`acc_size` bytes is misaligned when vaddr modulo 2^`acc_size` is nonzero. A misaligned data access reports fault code 1. Instruction fetches (`acc_kind` = 0) never report fault code 1.
- R4: A misaligned access reports fault code 1 even when it also violates the segment privilege rule.
- R5: An address whose top three bits are 100, issued in kernel mode, asserts `bypass` with `paddr` = vaddr with bits 31:29 cleared, and deasserts `needs_tlb`.
- R6: An address whose top three bits are 100, issued outside kernel mode, reports fault code 2 for a fetch and fault code 3 for a data access.
- R7: An address whose top three bits are 101 bypasses with `paddr` = vaddr with bits 31:29 cleared, in every mode.
- R8: `cacheable` is low exactly when vaddr bits 31 and 29 are both set, and this holds for every request, including faulting ones.
- R9: On any nonzero fault code, `bad_vaddr` equals the request address. When there is no fault it is zero.
- R10: Without a fault, addresses whose top three bits are neither 100 nor 101 assert `needs_tlb` with `bypass` low. With a fault, `bypass`, `needs_tlb` and `paddr` are all zero.
- R11: Results appear in the cycle after `req_valid`, with `out_valid` high for exactly that cycle. After reset, `out_valid` and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| vaddr | input | 32 | Virtual address |
| acc_size | input | 2 | log2 of access size in bytes |
| acc_kind | input | 2 | 0 = fetch, 1 = load, 2 or 3 = store |
| status | input | 32 | Processor status word |
| out_valid | output | 1 | Result strobe |
| mode | output | 2 | Decoded operating mode |
| bypass | output | 1 | Address mapped directly, no TLB |
| paddr | output | 32 | Direct physical address when bypassing |
| needs_tlb | output | 1 | Address must be translated by the TLB |
| fault | output | 2 | 0 none, 1 alignment, 2 fetch segment error, 3 data segment error |
| bad_vaddr | output | 32 | Faulting virtual address |
| cacheable | output | 1 | Access may be cached |

## Verification
Every output comes from one register stage. A request driven before a rising edge therefore has all of its results due at that edge, and they stay there until the next request. The bench drives on the falling edge and samples on the following falling edge, half a period after the results become visible. Between requests it drops `req_valid` once to confirm that `out_valid` falls on the very next edge. The sweep covers every top-three-bit segment, every size and kind, several low offsets and eight status words that cover each mode rule.

// File: rtl/addr_seg_check.sv
module addr_seg_check #(
  parameter int VA_W   = 32,
  parameter int ST_W   = 32,
  parameter int SZ_W   = 2,
  parameter int KIND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [SZ_W-1:0]   acc_size,
  input  logic [KIND_W-1:0] acc_kind,
  input  logic [ST_W-1:0]   status,
  output logic              out_valid,
  output logic [1:0]        mode,
  output logic              bypass,
  output logic [VA_W-1:0]   paddr,
  output logic              needs_tlb,
  output logic [1:0]        fault,
  output logic [VA_W-1:0]   bad_vaddr,
  output logic              cacheable
);

  localparam int SEG_W = 3;
  localparam int PA_W  = VA_W - SEG_W;
  localparam logic [1:0] M_KERN = 2'd0, M_SUP = 2'd1, M_USR = 2'd2;
  localparam logic [1:0] F_NONE = 2'd0, F_ALIGN = 2'd1, F_SEG_I = 2'd2, F_SEG_D = 2'd3;

  logic [1:0] ksu;
  logic       kern_force;
  logic [1:0] mode_c;

  assign ksu        = status[4:3];
  assign kern_force = status[28] | status[2] | status[1];

  always_comb begin
    if (kern_force || ksu == 2'b00) mode_c = M_KERN;
    else if (ksu == 2'b01)          mode_c = M_SUP;
    else                            mode_c = M_USR;
  end

  logic             is_data;
  logic [VA_W-1:0]  size_mask;
  logic             misalign;
  logic [SEG_W-1:0] seg;
  logic             in_k0, in_k1, priv_err;
  logic [1:0]       fault_c;
  logic             direct_c;

  assign is_data   = |acc_kind;
  assign size_mask = (VA_W'(1) << acc_size) - VA_W'(1);
  assign misalign  = is_data && |(vaddr & size_mask);
  assign seg       = vaddr[VA_W-1 -: SEG_W];
  assign in_k0     = seg == 3'b100;
  assign in_k1     = seg == 3'b101;
  assign priv_err  = in_k0 && mode_c != M_KERN;

  always_comb begin
    if (misalign)      fault_c = F_ALIGN;
    else if (priv_err) fault_c = is_data ? F_SEG_D : F_SEG_I;
    else               fault_c = F_NONE;
  end

  assign direct_c = (in_k0 || in_k1) && fault_c == F_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mode      <= M_KERN;
      bypass    <= 1'b0;
      paddr     <= '0;
      needs_tlb <= 1'b0;
      fault     <= F_NONE;
      bad_vaddr <= '0;
      cacheable <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        mode      <= mode_c;
        bypass    <= direct_c;
        paddr     <= direct_c ? {{SEG_W{1'b0}}, vaddr[PA_W-1:0]} : '0;
        needs_tlb <= !in_k0 && !in_k1 && fault_c == F_NONE;
        fault     <= fault_c;
        bad_vaddr <= fault_c != F_NONE ? vaddr : '0;
        cacheable <= !(vaddr[VA_W-1] && vaddr[VA_W-3]);
      end
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R11
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);
  // R10
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(bypass && needs_tlb));
  // R10
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fault != F_NONE) |-> (!bypass && !needs_tlb && paddr == '0));
  // R5
  paddr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> paddr[VA_W-1 -: SEG_W] == '0);
  // R9
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fault == F_NONE) |-> bad_vaddr == '0);
  // R4
  align_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_data && (vaddr[0] && acc_size != '0)) |=> fault == F_ALIGN);

endmodule

// File: tb/test_addr_seg_check.sv
module test_addr_seg_check;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  acc_size = '0;
  logic [1:0]  acc_kind = '0;
  logic [31:0] status = '0;
  logic        out_valid, bypass, needs_tlb, cacheable;
  logic [1:0]  mode, fault;
  logic [31:0] paddr, bad_vaddr;

  int total = 0;
  int bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  addr_seg_check i_addr_seg_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr),
    .acc_size(acc_size), .acc_kind(acc_kind), .status(status),
    .out_valid(out_valid), .mode(mode), .bypass(bypass), .paddr(paddr),
    .needs_tlb(needs_tlb), .fault(fault), .bad_vaddr(bad_vaddr),
    .cacheable(cacheable)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (va=%h sz=%0d kind=%0d st=%h)",
               req, act, exp, vaddr, acc_size, acc_kind, status);
    end
  endtask

  logic [31:0] st_list [8] = '{32'h0, 32'h8, 32'h10, 32'h18,
                               32'h12, 32'h14, 32'h1000_0010, 32'h1000_0008};
  logic [31:0] off_list [4] = '{32'h0, 32'h1, 32'h2, 32'h6};

  initial begin
    #(CLK_PER * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int em, ef, ebits, top;
    logic ebyp, etlb, ecach;
    logic [31:0] epa, ebad;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {31'b0, out_valid}, 0);
    chk("R11", {28'b0, fault, mode}, 0);
    chk("R11", {29'b0, bypass, needs_tlb, cacheable}, 0);
    chk("R11", paddr | bad_vaddr, 0);
    rst_n = 1'b1;
    for (int s = 0; s < 8; s++) begin
      for (int t = 0; t < 8; t++) begin
        for (int o = 0; o < 4; o++) begin
          for (int z = 0; z < 4; z++) begin
            for (int k = 0; k < 4; k++) begin
              @(negedge clk);
              status = st_list[s];
              vaddr = (32'(t) << 29) | 32'h0012_3400 | off_list[o];
              acc_size = 2'(z);
              acc_kind = 2'(k);
              req_valid = 1'b1;
              ebits = (status >> 3) % 4;
              if (((status >> 28) % 2) == 1 || ((status >> 1) % 4) != 0 || ebits == 0) em = 0;
              else if (ebits == 1) em = 1;
              else em = 2;
              top = t;
              ef = 0;
              if (k != 0 && (vaddr % (32'd1 << z)) != 0) ef = 1;
              else if (top == 4 && em != 0) ef = (k == 0) ? 2 : 3;
              ebyp = (ef == 0) && (top == 4 || top == 5);
              etlb = (ef == 0) && top != 4 && top != 5;
              epa = ebyp ? vaddr % 32'h2000_0000 : 0;
              ebad = (ef != 0) ? vaddr : 0;
              ecach = !(top == 5 || top == 7);
              @(negedge clk);
              chk("R11", {31'b0, out_valid}, 1);
              chk((ebits == 0 || em == 0) ? "R1" : "R2", {30'b0, mode}, em);
              chk(ef == 1 ? "R3" : (ef >= 2 ? "R6" : "R3"), {30'b0, fault}, ef);
              if (ef == 1 && top == 4 && em != 0) chk("R4", {30'b0, fault}, 1);
              chk(top == 5 ? "R7" : "R5", {31'b0, bypass}, {31'b0, ebyp});
              chk(top == 5 ? "R7" : "R5", paddr, epa);
              chk("R10", {31'b0, needs_tlb}, {31'b0, etlb});
              chk("R9", bad_vaddr, ebad);
              chk("R8", {31'b0, cacheable}, {31'b0, ecach});
              if (k == 3 && o == 3) begin
                req_valid = 1'b0;
                @(negedge clk);
                // R11 strobe drops with no request
                chk("R11", {31'b0, out_valid}, 0);
              end
            end
          end
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule